// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master for external Ethernet PHYs that uses IEEE 802.3 Clause 45 indirect addressing. Software sees four 32-bit registers, chosen by a 2-bit select: configuration/status, command, register-number and data. The block derives the management clock (MDC) from the system clock through a programmable divider. It drives the bidirectional data line through three separate signals: an output, an output enable and an input sampled from the pad.

Every Clause 45 access takes two phases, and software starts each one with a register write. First, a write to the register-number register sends an address frame. Second, software either writes the data register, which sends a write frame, or writes the command register with its read bit set, which sends a read frame. The status register shows a busy flag for the whole of any frame. The data register has its own busy flag that covers only the data frames. A read in which the PHY fails to pull the line low during turnaround sets an error flag.

Top module: `mdio45_master`

## Requirements
- R1: After reset the status register reads busy (bit 0) = 0, read error (bit 1) = 0 and divider (bits 15:8) = 100. MDC and the output enable are both low.
- R2: While a frame runs, MDC stays low for D system clocks, then high for D clocks, where D is the divider field (a value of 0 acts as 1). MDC is low whenever no frame runs. A frame lasts exactly 128·D clocks.
- R3: A write to select 2 (register number, bits 15:0) while idle starts an address frame. The frame is 32 ones, then 00, opcode 00, the port address, the device address, turnaround 10 and the register number, each field MSB first. The register reads back the number that was written.
- R4: A write to select 3 (data, bits 15:0) while idle starts a write frame with opcode 01 that carries the written data. Data-register bit 31 is 1 during write and read frames and 0 during address frames.
- R5: A write to select 1 (command) while idle loads the port address from bits 4:0 and the device address from bits 12:8. The command register reads back both fields, with bit 15 reading as 0. If bit 15 is set, the write also starts a read frame with opcode 11; if bit 15 is clear, no frame starts.
- R6: During a read frame the output enable is low for both turnaround bits and all 16 data bits. The input is sampled when MDC rises, MSB first. The captured value then appears in data-register bits 15:0.
- R7: If the input is high on the MDC rise of the second turnaround bit of a read, status bit 1 is set. The start of the next frame clears it.
- R8: Writes to any of the four registers are ignored while a frame is in progress.
- R9: During a frame the driven data bit changes only at a falling edge of MDC. The output enable is high only while a frame runs.
- R10: Status bit 0 becomes 1 on the clock edge that accepts a frame-starting write and stays 1 until the frame's last MDC falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 command, 2 register number, 3 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value driven to the pad |
| mdio_oe | output | 1 | Pad drive enable |
| mdio_in | input | 1 | Data value seen at the pad |

## Verification
Some properties are checked on every cycle. MDC is low whenever the block is idle. The pad is driven only inside a frame. The driven bit changes only at falling MDC edges. The data-side busy flag never appears without the overall busy flag. The read-error flag is clear whenever a new frame starts. Other behaviour needs the bench's scenarios: the exact bit content of each frame kind, the frame length in clocks for two divider values, the value captured from a simulated PHY, the error raised by a missing turnaround drive, and the fact that writes arriving mid-frame change nothing. For these the bench compares the pins against its reference model on every clock and reads the registers back.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int PHY_AW     = 5;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } frame_op_e;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_REGN = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;
endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;
  logic             mdc_q, mdc_d, wrap;

  always_comb begin
    limit = (div == '0) ? '0 : div - DIV_W'(1);
    wrap  = run && (cnt_q == limit);
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
    if (!run)      mdc_d = 1'b0;
    else if (wrap) mdc_d = ~mdc_q;
    else           mdc_d = mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = wrap & ~mdc_q;
  assign fall_stb = wrap & mdc_q;
endmodule

// File: rtl/mdio45_frame.sv
module mdio45_frame
  import mdio45_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_op_e         op,
  input  logic [PHY_AW-1:0] port,
  input  logic [PHY_AW-1:0] dev,
  input  logic [15:0]       payload,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_in,
  output logic              busy,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_err_set,
  output logic [15:0]       rd_data
);
  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      sr_q, sr_d;
  logic [15:0]      rd_q, rd_d;
  frame_op_e        op_q, op_d;
  logic [1:0]       ta_bits;
  logic             is_read, last_bit;

  always_comb begin
    ta_bits    = (op == OP_READ) ? 2'b11 : 2'b10;
    is_read    = (op_q == OP_READ);
    last_bit   = (idx_q == IDX_W'(FRAME_LEN - 1));
    done       = active_q && fall_stb && last_bit;
    rd_err_set = active_q && rise_stb && is_read &&
                 (idx_q == IDX_W'(TA_FIRST + 1)) && mdio_in;

    active_d = active_q;
    idx_d    = idx_q;
    sr_d     = sr_q;
    rd_d     = rd_q;
    op_d     = op_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      op_d     = op;
      sr_d     = {2'b00, op, port, dev, ta_bits, payload};
    end else if (active_q) begin
      if (rise_stb && is_read && (idx_q >= IDX_W'(DATA_FIRST)))
        rd_d = {rd_q[14:0], mdio_in};
      if (fall_stb) begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q >= IDX_W'(PRE_LEN)) sr_d = {sr_q[30:0], 1'b0};
        if (last_bit) active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sr_q     <= '0;
      rd_q     <= '0;
      op_q     <= OP_ADDR;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      sr_q     <= sr_d;
      rd_q     <= rd_d;
      op_q     <= op_d;
    end
  end

  assign busy     = active_q;
  assign mdio_out = (idx_q < IDX_W'(PRE_LEN)) ? 1'b1 : sr_q[31];
  assign mdio_oe  = active_q && !(is_read && (idx_q >= IDX_W'(TA_FIRST)));
  assign rd_data  = rd_q;
endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs
  import mdio45_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              rd_err_set,
  input  logic [15:0]       rd_data,
  output logic              start,
  output frame_op_e         op,
  output logic [PHY_AW-1:0] port,
  output logic [PHY_AW-1:0] dev,
  output logic [15:0]       payload,
  output logic [DIV_W-1:0]  div
);
  logic [DIV_W-1:0]  div_q, div_d;
  logic [PHY_AW-1:0] port_q, port_d, dev_q, dev_d;
  logic [15:0]       regn_q, regn_d, data_q, data_d;
  logic              data_pend_q, data_pend_d, rd_pend_q, rd_pend_d;
  logic              rd_err_q, rd_err_d;
  logic              acc, wr_stat, wr_cmd, go_addr, go_write, go_read;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:16];

  always_comb begin
    acc      = wr_en && !busy;
    wr_stat  = acc && (sel == SEL_STAT);
    wr_cmd   = acc && (sel == SEL_CMD);
    go_addr  = acc && (sel == SEL_REGN);
    go_write = acc && (sel == SEL_DATA);
    go_read  = wr_cmd && wdata[15];
    start    = go_addr || go_write || go_read;
    op       = go_read ? OP_READ : (go_write ? OP_WRITE : OP_ADDR);
    port     = wr_cmd ? wdata[PHY_AW-1:0] : port_q;
    dev      = wr_cmd ? wdata[8 +: PHY_AW] : dev_q;
    payload  = wdata[15:0];

    div_d       = wr_stat ? wdata[8 +: DIV_W] : div_q;
    port_d      = port;
    dev_d       = dev;
    regn_d      = go_addr ? wdata[15:0] : regn_q;
    data_d      = data_q;
    data_pend_d = data_pend_q;
    rd_pend_d   = rd_pend_q;
    rd_err_d    = rd_err_q;
    if (go_write) data_d = wdata[15:0];
    else if (done && rd_pend_q) data_d = rd_data;
    if (go_write || go_read) data_pend_d = 1'b1;
    else if (done)           data_pend_d = 1'b0;
    if (go_read)   rd_pend_d = 1'b1;
    else if (done) rd_pend_d = 1'b0;
    if (start)           rd_err_d = 1'b0;
    else if (rd_err_set) rd_err_d = 1'b1;

    rdata = '0;
    case (sel)
      SEL_STAT: begin
        rdata[8 +: DIV_W] = div_q;
        rdata[1]          = rd_err_q;
        rdata[0]          = busy;
      end
      SEL_CMD: begin
        rdata[PHY_AW-1:0]  = port_q;
        rdata[8 +: PHY_AW] = dev_q;
      end
      SEL_REGN: rdata[15:0] = regn_q;
      default: begin
        rdata[31]   = data_pend_q;
        rdata[15:0] = data_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= DIV_W'(DIV_RST);
      port_q      <= '0;
      dev_q       <= '0;
      regn_q      <= '0;
      data_q      <= '0;
      data_pend_q <= 1'b0;
      rd_pend_q   <= 1'b0;
      rd_err_q    <= 1'b0;
    end else begin
      div_q       <= div_d;
      port_q      <= port_d;
      dev_q       <= dev_d;
      regn_q      <= regn_d;
      data_q      <= data_d;
      data_pend_q <= data_pend_d;
      rd_pend_q   <= rd_pend_d;
      rd_err_q    <= rd_err_d;
    end
  end

  assign div = div_q;
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              frm_busy, frm_done, frm_err, frm_start;
  logic              rise_stb, fall_stb;
  frame_op_e         frm_op;
  logic [PHY_AW-1:0] frm_port, frm_dev;
  logic [15:0]       frm_payload, frm_rd;
  logic [DIV_W-1:0]  div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio45_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(frm_busy),
    .done(frm_done), .rd_err_set(frm_err), .rd_data(frm_rd),
    .start(frm_start), .op(frm_op), .port(frm_port), .dev(frm_dev),
    .payload(frm_payload), .div(div)
  );

  mdio45_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_int_n), .run(frm_busy), .div(div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio45_frame u_frm (
    .clk(clk), .rst_n(rst_int_n), .start(frm_start), .op(frm_op),
    .port(frm_port), .dev(frm_dev), .payload(frm_payload),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_in(mdio_in),
    .busy(frm_busy), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .done(frm_done), .rd_err_set(frm_err), .rd_data(frm_rd)
  );
endmodule

// File: rtl/mdio45_checker.sv
module mdio45_checker (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_out,
  input logic mdio_oe,
  input logic busy,
  input logic data_busy,
  input logic rd_err
);
  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R2

  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R9

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$stable(mdio_out))
      |-> $fell(mdc)); // R9

  AST_DBUSY_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    data_busy |-> busy); // R4

  AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rd_err); // R7
endmodule

bind mdio45_master mdio45_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
  .mdio_oe(mdio_oe), .busy(frm_busy), .data_busy(u_regs.data_pend_q),
  .rd_err(u_regs.rd_err_q)
);

// File: tb/mdio45_master_tb.sv
module mdio45_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, mdio_in;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_out, mdio_oe;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  mdio45_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: pin-level behaviour kept in integers and a frame vector
  int          m_active, m_idx, m_cnt, m_div, m_mdc, m_op;
  logic [4:0]  m_port, m_dev;
  logic [63:0] m_frame;
  logic [15:0] phy_word;
  logic        phy_ta;
  bit          model_on = 0;

  function automatic logic [63:0] mk_frame(int op, logic [4:0] p, logic [4:0] d, logic [15:0] v);
    logic [1:0] ta = (op == 3) ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b00, 2'(op), p, d, ta, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_idx = 0; m_cnt = 0; m_div = 100; m_mdc = 0; m_op = 0;
      m_port = '0; m_dev = '0; m_frame = '0;
    end else if (m_active == 0) begin
      if (reg_wr) begin
        case (reg_sel)
          2'd0: m_div = int'(reg_wdata[15:8]);
          2'd1: begin
            m_port = reg_wdata[4:0];
            m_dev  = reg_wdata[12:8];
            if (reg_wdata[15]) begin
              m_op = 3; m_frame = mk_frame(3, m_port, m_dev, 16'h0);
              m_active = 1; m_idx = 0; m_cnt = 0;
            end
          end
          2'd2: begin
            m_op = 0; m_frame = mk_frame(0, m_port, m_dev, reg_wdata[15:0]);
            m_active = 1; m_idx = 0; m_cnt = 0;
          end
          default: begin
            m_op = 1; m_frame = mk_frame(1, m_port, m_dev, reg_wdata[15:0]);
            m_active = 1; m_idx = 0; m_cnt = 0;
          end
        endcase
      end
    end else begin
      if (m_cnt == ((m_div == 0) ? 1 : m_div) - 1) begin
        m_cnt = 0;
        if (m_mdc == 0) m_mdc = 1;
        else begin
          m_mdc = 0;
          if (m_idx == 63) m_active = 0;
          m_idx = (m_idx == 63) ? 0 : m_idx + 1;
        end
      end else m_cnt++;
    end
  end

  // Pin comparison against the model, plus the simulated PHY, at each falling edge
  always @(negedge clk) begin
    if (model_on) begin
      bit exp_oe;
      exp_oe = (m_active != 0) && !(m_op == 3 && m_idx >= 46);
      chk("R2 mdc", {31'b0, mdc}, {31'b0, (m_mdc != 0)});
      chk("R6/R9 mdio_oe", {31'b0, mdio_oe}, {31'b0, exp_oe});
      if (exp_oe) chk("R3 mdio_out", {31'b0, mdio_out}, {31'b0, m_frame[63 - m_idx]});
    end
    if (m_active != 0 && m_op == 3 && m_idx >= 46) begin
      if (m_idx == 46)      mdio_in = 1'b1;
      else if (m_idx == 47) mdio_in = phy_ta;
      else                  mdio_in = phy_word[63 - m_idx];
    end else mdio_in = 1'b1;
  end

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] v;
    n = 0;
    rd_reg(2'd0, v);
    while (v[0] && n < 30000) begin
      n++;
      @(negedge clk);
      rd_reg(2'd0, v);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    mdio_in = 1'b1; phy_word = '0; phy_ta = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 status", v, 32'h0000_6400);
    chk("R1 pins", {30'b0, mdc, mdio_oe}, 32'h0);
    rd_reg(2'd3, v); chk("R1 data", v, 32'h0);

    // R2 divider programming
    wr_reg(2'd0, 32'h0000_0200);
    rd_reg(2'd0, v); chk("R2 div readback", v, 32'h0000_0200);

    // R5 command write without read bit only loads fields
    wr_reg(2'd1, 32'h0000_1F0A);
    repeat (6) @(negedge clk);
    rd_reg(2'd0, v); chk("R5 no frame", v, 32'h0000_0200);
    rd_reg(2'd1, v); chk("R5 cmd readback", v, 32'h0000_1F0A);

    // R3 address frame, R10 busy, R4 data busy clear
    wr_reg(2'd2, 32'h0000_BEEF);
    rd_reg(2'd0, v); chk("R10 busy set", {31'b0, v[0]}, 32'h1);
    rd_reg(2'd3, v); chk("R4 dbusy on addr frame", {31'b0, v[31]}, 32'h0);

    // R8 writes during a frame are ignored
    wr_reg(2'd3, 32'h0000_1234);
    wr_reg(2'd2, 32'h0000_1111);
    wr_reg(2'd1, 32'h0000_8305);
    wr_reg(2'd0, 32'h0000_0500);
    busy_len(n);
    repeat (8) @(negedge clk);
    rd_reg(2'd0, v); chk("R8 div kept / idle", v, 32'h0000_0200);
    rd_reg(2'd2, v); chk("R3/R8 regnum", v, 32'h0000_BEEF);
    rd_reg(2'd3, v); chk("R8 data kept", v, 32'h0);
    rd_reg(2'd1, v); chk("R8 cmd kept", v, 32'h0000_1F0A);

    // R4 write frame and R2 frame length at D=2
    wr_reg(2'd3, 32'h0000_A5C3);
    rd_reg(2'd3, v); chk("R4 dbusy on write", {31'b0, v[31]}, 32'h1);
    busy_len(n); chk("R2/R10 length D=2", n, 32'd256);
    rd_reg(2'd3, v); chk("R4 data after write", v, 32'h0000_A5C3);

    // R6 read frame with a good turnaround
    phy_word = 16'h5A96; phy_ta = 1'b0;
    wr_reg(2'd1, 32'h0000_9F0A);
    rd_reg(2'd3, v); chk("R4 dbusy on read", {31'b0, v[31]}, 32'h1);
    busy_len(n);
    rd_reg(2'd3, v); chk("R6 read data", v, 32'h0000_5A96);
    rd_reg(2'd0, v); chk("R7 no error", {30'b0, v[1:0]}, 32'h0);

    // R7 missing turnaround drive
    phy_word = 16'h0F0F; phy_ta = 1'b1;
    wr_reg(2'd1, 32'h0000_8203);
    busy_len(n);
    rd_reg(2'd0, v); chk("R7 error set", {30'b0, v[1:0]}, 32'h2);
    rd_reg(2'd1, v); chk("R5 cmd fields", v, 32'h0000_0203);

    // R7 cleared at next start; R2 length at D=100
    wr_reg(2'd0, 32'h0000_6400);
    wr_reg(2'd2, 32'h0000_0123);
    rd_reg(2'd0, v); chk("R7 error cleared", {30'b0, v[1:0]}, 32'h1);
    busy_len(n); chk("R2/R10 length D=100", n, 32'd12800);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule